// File: doc/BRIEF.md
# External chip-select decoder

This block sits between a processor's external-bus request path and the pins of an external memory bus. It holds four address regions. Each region is defined by a start address on a 64 KB boundary and a mask that widens it, plus an enable, a bus-width code, a wait count and a dummy-cycle count. Every bus request address is compared against all four regions at once. The winning region's active-low chip-select is driven, and its width, wait and dummy settings are handed to the bus controller together with the request.

Requests enter on a valid/ready stream and leave on a valid/ready stream through a single output register.

- An input request is taken on any cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is low only while a decoded result is held and `rsp_ready` is low.
- While stalled, every response output stays unchanged.
- The chip-select lines come straight from flops, so they cannot glitch.

Configuration is loaded through a plain write port. The external ready/wait pin is sampled into a flop and passed on with the selected wait count.

Top module: `ext_cs_decoder`

## Requirements
- R1: After reset `rsp_valid` is 0, `cs_n` is 4'b1111, `req_ready` is 1, and all regions are disabled with base and mask zero. A request then decodes to no region.
- R2: A region matches when every compared address bit equals the start address. Start bits 31..16 come from the 16-bit base, and start bits below 16 are zero.
- R3: For regions 0 and 1, mask bit i (1 = ignore) covers address bit 14+i, so the range is A29..A14. A31 and A30 are always compared, and A13..A0 are never compared.
- R4: For regions 2 and 3, mask bit i covers address bit 15+i, so the range is A30..A15. A31 is always compared, and A14..A0 are never compared.
- R5: A region whose enable bit is 0 never asserts its chip-select.
- R6: No chip-select asserts for an address whose bits 31..24 are 8'hFF, whatever the configuration.
- R7: When several enabled regions match, only the lowest-numbered one asserts its chip-select.
- R8: With a match, the response carries that region's width, wait and dummy values with `rsp_nosel`=0. Without a match it carries the defaults (width 1, wait 7, dummy 0), sets `rsp_nosel`=1 and keeps `cs_n` at 4'b1111.
- R9: The response appears on the cycle after acceptance. `req_ready` equals `!rsp_valid || rsp_ready`, and while `rsp_valid && !rsp_ready` every response output holds.
- R10: `cs_n` is 4'b1111 whenever `rsp_valid` is 0, and at most one `cs_n` bit is low.
- R11: `rdy_q` equals `ext_rdy` from the previous clock.
- R12: `cfg_idx[2:1]` selects the region. With `cfg_idx[0]`=0, `cfg_wdata[15:0]` is the base and `[31:16]` is the mask. With `cfg_idx[0]`=1, bit 0 is enable, [2:1] width, [6:3] wait and [8:7] dummy. A write is applied at the clock edge and affects requests accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region (bits 2:1) and word select (bit 0) |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Physical bus address |
| ext_rdy | input | 1 | External ready/wait pin |
| rsp_valid | output | 1 | Decoded response valid |
| rsp_ready | input | 1 | Bus controller takes the response |
| cs_n | output | 4 | Active-low chip-selects, one per region |
| rsp_nosel | output | 1 | No region selected |
| rsp_width | output | 2 | Selected bus-width code |
| rsp_wait | output | 4 | Selected wait count |
| rsp_dummy | output | 2 | Selected dummy-cycle count |
| rdy_q | output | 1 | Registered `ext_rdy` |

## Verification
The assertions assume three things about the inputs:

- `req_addr` is meaningful only in a cycle where a request is accepted.
- The consumer obeys the stall rule, so a held response is observed rather than replaced.
- Configuration writes never land on the same edge as an accepted request the check depends on.

The stimulus keeps to these assumptions. Configuration is written only while the request stream is idle. Each request is presented for exactly one accepting cycle. Back-pressure is applied only in a dedicated phase where the held response and the blocked follower are both observed before release.

// File: rtl/ext_cs_pkg.sv
package ext_cs_pkg;
  parameter int NUM_REGIONS = 4;
  parameter int ADDR_W      = 32;
  parameter int BASE_W      = 16;
  parameter int MASK_W      = 16;
  parameter int WIDTH_W     = 2;
  parameter int WAIT_W      = 4;
  parameter int DUMMY_W     = 2;

  // Control-word field positions
  localparam int EN_BIT      = 0;
  localparam int WIDTH_LSB   = EN_BIT + 1;
  localparam int WAIT_LSB    = WIDTH_LSB + WIDTH_W;
  localparam int DUMMY_LSB   = WAIT_LSB + WAIT_W;
  localparam int IDX_W       = $clog2(NUM_REGIONS) + 1;

  typedef struct packed {
    logic [BASE_W-1:0]  base;
    logic [MASK_W-1:0]  mask;
    logic               en;
    logic [WIDTH_W-1:0] width;
    logic [WAIT_W-1:0]  waitc;
    logic [DUMMY_W-1:0] dummy;
  } region_cfg_t;

  // Lowest maskable address bit per region: pairs 0/1 start at 14, 2/3 at 15
  function automatic int mask_lo_bit(input int region);
    return (region < 2) ? 14 : 15;
  endfunction
endpackage

// File: rtl/ext_cs_cfg_regs.sv
module ext_cs_cfg_regs
  import ext_cs_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [IDX_W-1:0]                     cfg_idx,
  input  logic [31:0]                          cfg_wdata,
  output region_cfg_t [NUM_REGIONS-1:0]        cfg_o
);
  localparam int RSEL_W = IDX_W - 1;

  region_cfg_t [NUM_REGIONS-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (cfg_idx[IDX_W-1:1] == RSEL_W'(r)) begin
          if (!cfg_idx[0]) begin
            cfg_q[r].base <= cfg_wdata[BASE_W-1:0];
            cfg_q[r].mask <= cfg_wdata[BASE_W +: MASK_W];
          end else begin
            cfg_q[r].en    <= cfg_wdata[EN_BIT];
            cfg_q[r].width <= cfg_wdata[WIDTH_LSB +: WIDTH_W];
            cfg_q[r].waitc <= cfg_wdata[WAIT_LSB +: WAIT_W];
            cfg_q[r].dummy <= cfg_wdata[DUMMY_LSB +: DUMMY_W];
          end
        end
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ext_cs_region_match.sv
module ext_cs_region_match
  import ext_cs_pkg::*;
#(
  parameter int LO_BIT = 14
) (
  input  region_cfg_t       cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              blocked,
  output logic              hit
);
  localparam int CW      = ADDR_W - LO_BIT;
  localparam int MASK_HI = LO_BIT + MASK_W - 1;
  localparam int BASE_LO = ADDR_W - BASE_W;

  logic [CW-1:0] expv;
  logic [CW-1:0] care;

  for (genvar b = LO_BIT; b < ADDR_W; b++) begin : g_bit
    if (b <= MASK_HI) begin : g_maskable
      assign care[b-LO_BIT] = ~cfg.mask[b-LO_BIT];
    end else begin : g_fixed
      assign care[b-LO_BIT] = 1'b1;
    end
    if (b >= BASE_LO) begin : g_base
      assign expv[b-LO_BIT] = cfg.base[b-BASE_LO];
    end else begin : g_zero
      assign expv[b-LO_BIT] = 1'b0;
    end
  end

  assign hit = cfg.en && !blocked &&
               (((addr[ADDR_W-1:LO_BIT] ^ expv) & care) == '0);
endmodule

// File: rtl/ext_cs_prio_pick.sv
module ext_cs_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] hit,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ext_cs_out_stage.sv
module ext_cs_out_stage #(
  parameter int PW = 8,
  parameter int N  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_payload,
  input  logic [N-1:0]  in_cs_n,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_payload,
  output logic [N-1:0]  out_cs_n
);
  logic          v_q;
  logic [PW-1:0] p_q;
  logic [N-1:0]  cs_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      p_q  <= '0;
      cs_q <= '1;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) begin
        p_q  <= in_payload;
        cs_q <= in_cs_n;
      end else begin
        cs_q <= '1;
      end
    end
  end

  assign out_valid   = v_q;
  assign out_payload = p_q;
  assign out_cs_n    = cs_q;
endmodule

// File: rtl/ext_cs_decoder.sv
module ext_cs_decoder
  import ext_cs_pkg::*;
#(
  parameter logic [WIDTH_W-1:0] DEF_WIDTH = 2'd1,
  parameter logic [WAIT_W-1:0]  DEF_WAIT  = 4'd7,
  parameter logic [DUMMY_W-1:0] DEF_DUMMY = 2'd0,
  parameter int                 INT_TAG_W = 8,
  parameter logic [INT_TAG_W-1:0] INT_TAG = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [31:0]            cfg_wdata,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   ext_rdy,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [NUM_REGIONS-1:0] cs_n,
  output logic                   rsp_nosel,
  output logic [WIDTH_W-1:0]     rsp_width,
  output logic [WAIT_W-1:0]      rsp_wait,
  output logic [DUMMY_W-1:0]     rsp_dummy,
  output logic                   rdy_q
);
  localparam int PW = 1 + WIDTH_W + WAIT_W + DUMMY_W;

  region_cfg_t [NUM_REGIONS-1:0] cfg;
  logic [NUM_REGIONS-1:0]        hit;
  logic [NUM_REGIONS-1:0]        grant;
  logic                          internal_win;
  logic [WIDTH_W-1:0]            sel_width;
  logic [WAIT_W-1:0]             sel_wait;
  logic [DUMMY_W-1:0]            sel_dummy;
  logic                          sel_none;
  logic [PW-1:0]                 in_payload;
  logic [PW-1:0]                 out_payload;

  ext_cs_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_o     (cfg)
  );

  assign internal_win = (req_addr[ADDR_W-1 -: INT_TAG_W] == INT_TAG);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    ext_cs_region_match #(.LO_BIT(mask_lo_bit(r))) u_match (
      .cfg     (cfg[r]),
      .addr    (req_addr),
      .blocked (internal_win),
      .hit     (hit[r])
    );
  end

  ext_cs_prio_pick #(.N(NUM_REGIONS)) u_pick (
    .hit   (hit),
    .grant (grant)
  );

  always_comb begin
    sel_width = '0;
    sel_wait  = '0;
    sel_dummy = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (grant[i]) begin
        sel_width |= cfg[i].width;
        sel_wait  |= cfg[i].waitc;
        sel_dummy |= cfg[i].dummy;
      end
    end
    sel_none = (grant == '0);
    if (sel_none) begin
      sel_width = DEF_WIDTH;
      sel_wait  = DEF_WAIT;
      sel_dummy = DEF_DUMMY;
    end
  end

  assign in_payload = {sel_none, sel_width, sel_wait, sel_dummy};

  ext_cs_out_stage #(.PW(PW), .N(NUM_REGIONS)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (req_valid),
    .in_ready    (req_ready),
    .in_payload  (in_payload),
    .in_cs_n     (~grant),
    .out_valid   (rsp_valid),
    .out_ready   (rsp_ready),
    .out_payload (out_payload),
    .out_cs_n    (cs_n)
  );

  assign {rsp_nosel, rsp_width, rsp_wait, rsp_dummy} = out_payload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= ext_rdy;
  end
endmodule

// File: rtl/ext_cs_decoder_chk.sv
module ext_cs_decoder_chk
  import ext_cs_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [ADDR_W-1:0]      req_addr,
  input logic                   ext_rdy,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [NUM_REGIONS-1:0] cs_n,
  input logic                   rsp_nosel,
  input logic [WIDTH_W-1:0]     rsp_width,
  input logic [WAIT_W-1:0]      rsp_wait,
  input logic [DUMMY_W-1:0]     rsp_dummy,
  input logic                   rdy_q
);
  logic              armed;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      last_addr <= '0;
    end else begin
      armed <= 1'b1;
      if (req_valid && req_ready) last_addr <= req_addr;
    end
  end

  // R10: idle response keeps every select high
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (cs_n == '1));

  // R10: never more than one select active
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R8: no-select flag agrees with the select lines
  a_r8_nosel_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_nosel == (cs_n == '1)));

  // R9: stalled response is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(cs_n) && $stable(rsp_nosel)
      && $stable(rsp_width) && $stable(rsp_wait) && $stable(rsp_dummy)));

  // R9: no acceptance while stalled
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R6: internal window never selects
  a_r6_internal_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && last_addr[ADDR_W-1 -: 8] == 8'hFF) |-> (cs_n == '1));

  // R11: ready pin sampled one clock later
  a_r11_rdy_delay: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (rdy_q == $past(ext_rdy)));
endmodule

bind ext_cs_decoder ext_cs_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .ext_rdy   (ext_rdy),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .cs_n      (cs_n),
  .rsp_nosel (rsp_nosel),
  .rsp_width (rsp_width),
  .rsp_wait  (rsp_wait),
  .rsp_dummy (rsp_dummy),
  .rdy_q     (rdy_q)
);

// File: tb/ext_cs_decoder_tb_top.sv
module ext_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        ext_rdy = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [3:0]  cs_n;
  logic        rsp_nosel;
  logic [1:0]  rsp_width;
  logic [3:0]  rsp_wait;
  logic [1:0]  rsp_dummy;
  logic        rdy_q;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // bench model of configuration
  logic [15:0] m_base [4];
  logic [15:0] m_mask [4];
  logic        m_en   [4];
  logic [1:0]  m_w    [4];
  logic [3:0]  m_wt   [4];
  logic [1:0]  m_d    [4];
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  ext_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .ext_rdy(ext_rdy), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .cs_n(cs_n), .rsp_nosel(rsp_nosel),
    .rsp_width(rsp_width), .rsp_wait(rsp_wait), .rsp_dummy(rsp_dummy),
    .rdy_q(rdy_q)
  );

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog expired: actual=%0d cycles expected<=150000", cycles);
        finish_run();
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic region_hit(input int r, input logic [31:0] a);
    int lo = (r < 2) ? 14 : 15;
    if (!m_en[r] || a[31:24] == 8'hFF) return 1'b0;
    for (int b = lo; b < 32; b++) begin
      logic e = (b >= 16) ? m_base[r][b-16] : 1'b0;
      if (b <= lo + 15 && m_mask[r][b-lo]) continue;
      if (a[b] != e) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic cfg_region(input int r, input logic [15:0] base, input logic [15:0] mask,
                            input logic en, input logic [1:0] w, input logic [3:0] wt,
                            input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = {r[1:0], 1'b0}; cfg_wdata = {mask, base};
    @(negedge clk);
    cfg_idx = {r[1:0], 1'b1}; cfg_wdata = {23'd0, d, wt, w, en};
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[r] = base; m_mask[r] = mask; m_en[r] = en;
    m_w[r] = w; m_wt[r] = wt; m_d[r] = d;
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] a, output string tag);
    int pick = -1;
    int nhit = 0;
    logic [3:0] csv = 4'hF;
    for (int r = 3; r >= 0; r--) if (region_hit(r, a)) begin pick = r; nhit++; end
    if (a[31:24] == 8'hFF) tag = "R6";
    else if (nhit > 1) tag = "R7";
    else if (pick < 0) tag = "R8";
    else if (pick < 2) tag = "R3";
    else tag = "R4";
    if (pick < 0) return {19'd0, 1'b1, csv, 2'd1, 4'd7, 2'd0};
    csv[pick] = 1'b0;
    return {19'd0, 1'b0, csv, m_w[pick], m_wt[pick], m_d[pick]};
  endfunction

  task automatic send(input logic [31:0] a, input string force_tag);
    string tag;
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    exp = expect_word(a, tag);
    if (force_tag != "") tag = force_tag;
    check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check(tag, {19'd0, rsp_nosel, cs_n, rsp_width, rsp_wait, rsp_dummy}, exp);
  endtask

  function automatic logic [31:0] next_rand();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  task automatic sweep();
    for (int r = 0; r < 4; r++) begin
      logic [31:0] st = {m_base[r], 16'h0000};
      send(st, "");
      for (int b = 0; b < 32; b++) send(st ^ (32'd1 << b), "");
    end
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x = next_rand();
      send(x, "");
      send({m_base[i % 4], 16'h0} | (x & 32'h007F_FFFF), "");
    end
    for (int i = 0; i < 8; i++) send(32'hFF00_0000 | (next_rand() & 32'h00FF_FFFF), "");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cs_n", {28'd0, cs_n}, 32'hF);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    for (int r = 0; r < 4; r++) begin
      m_base[r] = '0; m_mask[r] = '0; m_en[r] = 1'b0; m_w[r] = '0; m_wt[r] = '0; m_d[r] = '0;
    end
    send(32'h0000_0000, "R1");
    send(32'h1234_0000, "R1");
    @(negedge clk);
    check("R10 idle cs_n", {28'd0, cs_n}, 32'hF);

    // R12 / R2: directed configuration and exact-start match
    cfg_region(0, 16'h1000, 16'h0003, 1'b1, 2'd1, 4'd3, 2'd1);
    cfg_region(1, 16'h2000, 16'h00FF, 1'b1, 2'd2, 4'd5, 2'd2);
    cfg_region(2, 16'h4000, 16'h0001, 1'b1, 2'd0, 4'd9, 2'd3);
    cfg_region(3, 16'h1000, 16'hFFFF, 1'b1, 2'd3, 4'd15, 2'd0);
    send(32'h1000_0000, "R2");
    send(32'h1000_FFFF, "R12");
    send(32'h4000_7FFF, "R4");
    send(32'h4000_8000, "R4");
    send(32'h2003_C000, "R3");
    sweep();

    // wide masks: A31/A30 always compared for 0/1, A31 for 2/3
    cfg_region(0, 16'h0000, 16'hFFFF, 1'b1, 2'd2, 4'd1, 2'd1);
    cfg_region(1, 16'h4000, 16'h0000, 1'b1, 2'd1, 4'd2, 2'd2);
    cfg_region(2, 16'h8000, 16'hFFFF, 1'b1, 2'd3, 4'd4, 2'd3);
    cfg_region(3, 16'hFF00, 16'h0000, 1'b1, 2'd0, 4'd6, 2'd1);
    send(32'h3FFF_FFFF, "R3");
    send(32'h4000_0000, "R3");
    send(32'h8000_0000, "R4");
    send(32'hFEFF_FFFF, "R4");
    send(32'hFF00_0000, "R6");
    send(32'hFFFF_FFFF, "R6");
    sweep();

    // R5: all disabled
    for (int r = 0; r < 4; r++) cfg_region(r, 16'h1000, 16'hFFFF, 1'b0, 2'd3, 4'd3, 2'd3);
    send(32'h1000_0000, "R5");
    send(32'h0000_0000, "R5");
    send(32'h9000_0000, "R5");
    // R5: only region 2 enabled, lower regions would otherwise win
    cfg_region(2, 16'h1000, 16'hFFFF, 1'b1, 2'd2, 4'd11, 2'd1);
    send(32'h1000_0000, "R5");
    sweep();

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h1000_0000;
    @(negedge clk);
    req_addr = 32'h9000_0000;
    repeat (3) begin
      check("R9 held valid", {31'd0, rsp_valid}, 32'd1);
      check("R9 held cs_n", {28'd0, cs_n}, 32'hB);
      check("R9 held wait", {28'd0, rsp_wait}, 32'd11);
      check("R9 ready low", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 follower cs_n", {28'd0, cs_n}, 32'hF);
    check("R9 follower nosel", {31'd0, rsp_nosel}, 32'd1);
    @(negedge clk);
    check("R10 drained cs_n", {28'd0, cs_n}, 32'hF);
    check("R10 drained valid", {31'd0, rsp_valid}, 32'd0);

    // R11: ready pin sampling
    for (int i = 0; i < 6; i++) begin
      logic v = i[0] ^ i[2];
      @(negedge clk);
      ext_rdy = v;
      @(negedge clk);
      check("R11 rdy_q", {31'd0, rdy_q}, {31'd0, v});
    end

    finish_run();
  end
endmodule